// File: doc/BRIEF.md
# Halt-Aware Timer with Capture and Protected Status Flags

This block is a free-running up-counter with one input-capture channel and a two-bit status register. Its flags are a capture flag and an overflow flag. A system controller drives a halt line for debug. While halt is high, the counter stops and capture edges are dropped. A second control input picks how the status flags behave during a halt. They are either protected, so reads and writes leave them alone, or they can be cleared as usual.

Software clears a flag in two steps. First it reads the status register while the flag is set, which arms the clear. Then it writes a 0 to that flag's bit. A new event on the flag between the two steps sets the flag again and cancels the pending clear. When protection is on, a clear that was armed before the halt is kept through the halt. Software can then finish the clear after the halt ends.

Top module: `halt_timer_status`

## Requirements
- R1: When halt_i is low, the counter goes up by one on every clock edge and wraps from its all-ones value to zero.
- R2: When halt_i is high, the counter keeps its value.
- R3: A rising edge on cap_pin_i is found by comparing the pin with its value on the previous clock. When halt_i is low, that edge loads the counter value from just before the edge into the capture register and sets the capture flag, which is status bit 0.
- R4: Capture edges that arrive while halt_i is high are ignored. The capture register and the capture flag stay unchanged.
- R5: A flag is cleared in two steps. A status read (address 0) while the flag is set arms the clear. A later status write with that flag's bit at 0 clears the flag. A write without a prior arming leaves the flag set, and writing a 1 to a bit never clears it.
- R6: When halt_i is 1 and halt_clr_en_i is 0, status writes leave the flags and their arming unchanged. An arming made before the halt is kept, and a write of 0 after the halt clears the flag.
- R7: When halt_i is 1 and halt_clr_en_i is 1, the two-step clear works as usual, and a flag cleared this way stays cleared after the halt. halt_clr_en_i takes effect in the same cycle it is applied.
- R8: A set event between the read step and the write step re-sets the flag and cancels the arming, so the write has no effect.
- R9: The counter wrap sets the overflow flag (status bit 1). This flag follows the same clear and protection rules as the capture flag.
- R10: A status read during a protected halt does not arm a clear.
- R11: After reset, the counter, the capture register, both flags, their arming and rdata_o are all zero.
- R12: A read with rd_en_i high returns a value on rdata_o one clock later. Address 0 returns the status bits, address 1 the counter, address 2 the capture register, and address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Debug halt from the system controller |
| halt_clr_en_i | input | 1 | 1 allows flag clearing during a halt |
| cap_pin_i | input | 1 | Capture input; a rising edge triggers capture |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 2 | Status write data, one bit per flag |
| rdata_o | output | CNT_W | Registered read data |
| flag_o | output | 2 | Flag state: bit 0 capture, bit 1 overflow |

## Verification
The bench builds the block with CNT_W set to 8, so the counter wraps every 256 clocks. This puts the overflow flag and its two-step clear within reach of a short run. Reads go into a scoreboard queue with a mask, so status reads can ignore an overflow flag that sets while the capture-flag cases run. Each halt case is checked at the flag outputs and through register reads after halt_i falls. This shows whether the arming was kept, dropped or never made.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int FLAG_CAP  = 0;
  localparam int FLAG_OVF  = 1;
  localparam int NUM_FLAGS = 2;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CAPT   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (!halt_i) cnt_q <= cnt_q + 1'b1;
  end

  // the wrap event lines up with the edge that takes the count to zero
  assign wrap_o = !halt_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             event_o
);
  logic             pin_q;
  logic [CNT_W-1:0] cap_q;

  // the previous pin value is always tracked, so an edge that arrives
  // during a halt is used up and not replayed after the halt
  assign event_o = pin_i && !pin_q && !halt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      cap_q <= '0;
    end else begin
      pin_q <= pin_i;
      if (event_o) cap_q <= cnt_i;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic arm_rd_i,
  input  logic clr_wr_i,
  input  logic protect_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (!protect_i) begin
      if (clr_wr_i && armed_q) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (arm_rd_i && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/halt_timer_status.sv
module halt_timer_status
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 halt_i,
  input  logic                 halt_clr_en_i,
  input  logic                 cap_pin_i,
  input  logic                 rd_en_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           addr_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [CNT_W-1:0]     rdata_o,
  output logic [NUM_FLAGS-1:0] flag_o
);
  localparam int PAD_W = CNT_W - NUM_FLAGS;

  logic [CNT_W-1:0]     cnt_w;
  logic [CNT_W-1:0]     cap_w;
  logic                 wrap_w;
  logic                 cap_evt_w;
  logic [NUM_FLAGS-1:0] set_w;
  logic                 protect_w;
  logic                 st_rd_w;
  logic                 st_wr_w;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .halt_i(halt_i), .cnt_o(cnt_w), .wrap_o(wrap_w)
  );

  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .halt_i(halt_i), .pin_i(cap_pin_i),
    .cnt_i(cnt_w), .cap_o(cap_w), .event_o(cap_evt_w)
  );

  assign set_w[FLAG_CAP] = cap_evt_w;
  assign set_w[FLAG_OVF] = wrap_w;

  assign protect_w = halt_i && !halt_clr_en_i;
  assign st_rd_w   = rd_en_i && (addr_i == REG_STATUS);
  assign st_wr_w   = wr_en_i && (addr_i == REG_STATUS);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tmr_flag u_flag (
      .clk(clk), .rst(rst),
      .set_i(set_w[g]),
      .arm_rd_i(st_rd_w),
      .clr_wr_i(st_wr_w && !wdata_i[g]),
      .protect_i(protect_w),
      .flag_o(flag_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        REG_STATUS: rdata_o <= {{PAD_W{1'b0}}, flag_o};
        REG_COUNT:  rdata_o <= cnt_w;
        REG_CAPT:   rdata_o <= cap_w;
        default:    rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/halt_timer_status_chk.sv
module halt_timer_status_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             halt_i,
  input logic             clr_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cap_i,
  input logic [1:0]       flag_i
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !halt_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1)); // R1
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && halt_i) |=> $stable(cnt_i)); // R2
  AST_CAPT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (past_ok && halt_i) |=> $stable(cap_i)); // R4
  AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && halt_i && !clr_en_i) |=> $stable(flag_i)); // R6
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !halt_i && (cnt_i == {CNT_W{1'b1}})) |=> flag_i[1]); // R9
endmodule

bind halt_timer_status halt_timer_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .halt_i(halt_i), .clr_en_i(halt_clr_en_i),
  .cnt_i(cnt_w), .cap_i(cap_w), .flag_i(flag_o)
);

// File: tb/halt_timer_status_test.sv
module halt_timer_status_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          halt = 1'b0, clr_en = 1'b0, cap = 1'b0;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [1:0]    wdata = '0;
  logic [CW-1:0] rdata;
  logic [1:0]    flags;

  int checks = 0, failures = 0;

  typedef struct {
    logic [CW-1:0] exp;
    logic [CW-1:0] mask;
    string         tag;
  } item_t;
  item_t q[$];
  logic [CW-1:0] last_rd;
  logic          rd_seen = 1'b0;

  always #2 clk = ~clk;

  halt_timer_status #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .halt_i(halt), .halt_clr_en_i(clr_en),
    .cap_pin_i(cap), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .flag_o(flags)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      last_rd = rdata;
      if (it.mask != '0)
        check((rdata & it.mask) == (it.exp & it.mask), it.tag,
              int'(rdata & it.mask), int'(it.exp & it.mask));
    end
  end

  task automatic rd(input logic [1:0] a, input logic [CW-1:0] e,
                    input logic [CW-1:0] m, input string t);
    item_t it;
    it.exp = e; it.mask = m; it.tag = t;
    q.push_back(it);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
    #1;
  endtask

  task automatic set_halt(input logic h, input logic ce);
    @(negedge clk); halt = h; clr_en = ce;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CW-1:0] v, capv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    check(flags == 2'b00, "R11 flags after reset", flags, 0);
    check(rdata == '0, "R11 rdata after reset", rdata, 0);
    rd(2'd2, '0, '1, "R11 capture reg after reset");
    rd(2'd0, '0, '1, "R11 status after reset");
    rd(2'd3, '0, '1, "R12 unused address reads zero");

    // R9 wrap sets overflow flag; counter reads 1 just after
    for (int i = 0; i < 400 && !flags[1]; i++) @(negedge clk);
    check(flags[1] == 1'b1, "R9 overflow flag set on wrap", flags, 2);
    rd(2'd1, CW'(1), '1, "R1 counter wrapped to zero");
    rd(2'd0, 8'h02, 8'h02, "R9 status bit1 reads set");
    wr(2'b01);
    check(flags[1] == 1'b0, "R9 overflow cleared by two steps", flags[1], 0);

    // R1 / R12 counter advances
    rd(2'd1, '0, '0, "count sample");
    v = last_rd;
    rd(2'd1, CW'(v + 2), '1, "R1 counter advances one per clock");

    // R2 halt freeze
    set_halt(1'b1, 1'b0);
    rd(2'd1, '0, '0, "count sample in halt");
    v = last_rd;
    idle_cycles(5);
    rd(2'd1, v, '1, "R2 counter frozen in halt");
    set_halt(1'b0, 1'b0);

    // R3 capture
    rd(2'd1, '0, '0, "count sample");
    v = last_rd;
    pulse_cap();
    capv = CW'(v + 2);
    rd(2'd2, capv, '1, "R3 capture value");
    check(flags[0] == 1'b1, "R3 capture flag set", flags[0], 1);

    // R5 two-step clear
    wr(2'b10);
    check(flags[0] == 1'b1, "R5 write without arm keeps flag", flags[0], 1);
    rd(2'd0, 8'h01, 8'h01, "R5 status read arms");
    wr(2'b11);
    check(flags[0] == 1'b1, "R5 writing one does not clear", flags[0], 1);
    wr(2'b10);
    check(flags[0] == 1'b0, "R5 armed write clears", flags[0], 0);

    // R4 capture ignored in halt
    set_halt(1'b1, 1'b0);
    pulse_cap();
    rd(2'd2, capv, '1, "R4 capture reg unchanged in halt");
    check(flags[0] == 1'b0, "R4 capture flag unchanged in halt", flags[0], 0);
    set_halt(1'b0, 1'b0);

    // R8 re-set between steps cancels clear
    pulse_cap();
    rd(2'd0, 8'h01, 8'h01, "R8 arm read");
    pulse_cap();
    wr(2'b10);
    check(flags[0] == 1'b1, "R8 new event cancels pending clear", flags[0], 1);

    // R6 arming survives protected halt
    rd(2'd0, 8'h01, 8'h01, "R6 arm before halt");
    set_halt(1'b1, 1'b0);
    wr(2'b10);
    check(flags[0] == 1'b1, "R6 protected write ignored", flags[0], 1);
    rd(2'd0, 8'h01, 8'h01, "R6 status read in halt");
    set_halt(1'b0, 1'b0);
    wr(2'b10);
    check(flags[0] == 1'b0, "R6 second step after halt clears", flags[0], 0);

    // R10 read during protected halt does not arm
    pulse_cap();
    set_halt(1'b1, 1'b0);
    rd(2'd0, 8'h01, 8'h01, "R10 read in protected halt");
    set_halt(1'b0, 1'b0);
    wr(2'b10);
    check(flags[0] == 1'b1, "R10 halt read did not arm", flags[0], 1);

    // R7 clear allowed in halt, enable acts same cycle
    set_halt(1'b1, 1'b1);
    rd(2'd0, 8'h01, 8'h01, "R7 arm in halt");
    wr(2'b10);
    check(flags[0] == 1'b0, "R7 clear during halt", flags[0], 0);
    set_halt(1'b0, 1'b0);
    idle_cycles(3);
    check(flags[0] == 1'b0, "R7 stays cleared after halt", flags[0], 0);

    idle_cycles(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
endmodule